// File: doc/BRIEF.md
# Memory, Stack and Branch Instruction Executor

This block executes the memory-access, stack and control-transfer part of a small 16-bit instruction set. It owns the program counter, a downward-growing stack pointer and eight 16-bit general registers. It fetches each instruction word over one synchronous single-port memory port and decodes it. It then carries out a load, a store, a jump (unconditional, on zero, or on overflow), a push or a pop. Inside each instruction, a mode bit selects between a direct address carried in the word and an address or value taken from a register or an immediate field.

Every instruction walks through a fixed sequence: a fetch cycle that presents the program counter, a cycle that captures the returned word, and an execute cycle. A load or a pop needs one more cycle to receive the memory data. The memory returns read data one clock after the address is presented. Zero and overflow condition flags come from outside as plain inputs. A one-cycle retire pulse marks the end of each instruction, and unknown opcodes raise a one-cycle illegal pulse and otherwise behave as no-ops.

Top module: `mem_stack_unit`

## Requirements
- R1: After reset the program counter is 0, the stack pointer is 16'hFFFF, all eight registers hold 0, retire, illegal and mem_we are low, and the first fetch presents address 0.
- R2: Each instruction is fetched from the program counter. Retire pulses in its third cycle, or in its fourth for a load or a pop. The next fetch follows in the cycle after retire, and every instruction except a taken jump advances the program counter by one.
- R3: Opcode 4'b0110 loads register ir[11:9] from the zero-extended direct address ir[8:0].
- R4: Opcode 4'b0111 with ir[11]=0 writes register ir[2:0] to the zero-extended direct address ir[10:3].
- R5: Opcode 4'b0111 with ir[11]=1 writes register ir[2:0] to the full 16-bit address held in register ir[5:3].
- R6: Opcodes 4'b1000 (always), 4'b1001 and 4'b1010 with ir[11]=0 use the zero-extended target ir[10:0].
- R7: The same opcodes with ir[11]=1 take their target from register ir[2:0].
- R8: Opcode 4'b1001 is taken only when zero_flag is 1 during execute, and 4'b1010 only when ovf_flag is 1. A jump that is not taken advances the program counter by one. The flags have no effect on other instructions.
- R9: Opcode 4'b1100 with ir[8]=0 first decrements the stack pointer and then writes register ir[2:0] at the new stack pointer.
- R10: Opcode 4'b1100 with ir[8]=1 pushes the byte ir[7:0] sign-extended to 16 bits.
- R11: Opcode 4'b0011 with ir[11]=0 reads the word at the stack pointer into register ir[2:0] and then increments the stack pointer.
- R12: Opcode 4'b0011 with ir[11]=1 copies the word at the stack pointer to the zero-extended direct address ir[10:0] and increments the stack pointer.
- R13: Any other opcode raises illegal together with retire for one cycle. It writes nothing to memory or registers, and the program counter advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| zero_flag | input | 1 | Zero condition sampled by the zero-conditional jump |
| ovf_flag | input | 1 | Overflow condition sampled by the overflow-conditional jump |
| mem_addr | output | 16 | Memory address for fetch, data read or write |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| retire | output | 1 | One-cycle pulse when an instruction completes |
| illegal | output | 1 | One-cycle pulse for an unrecognised opcode |

## Verification
A corrupted program counter shows up at the very next fetch address, one cycle after retire. A wrong stack pointer shows up at the address of the next push write, or in the data that the next pop moves into memory. A register with a wrong value or a mis-decoded mode bit appears only when a later store or push carries that register to the memory port, so each test program stores its registers soon after setting them. Sequencing errors change the number of cycles from a fetch to its retire pulse, and the bench times every instruction.

// File: rtl/msu_pkg.sv
package msu_pkg;

   // instruction format widths, fixed by the encoding
   localparam int unsigned IW  = 16;
   localparam int unsigned RIW = 3;
   localparam int unsigned DFW = 11;

   localparam logic [3:0] OPC_POP  = 4'b0011;
   localparam logic [3:0] OPC_LD   = 4'b0110;
   localparam logic [3:0] OPC_ST   = 4'b0111;
   localparam logic [3:0] OPC_JMP  = 4'b1000;
   localparam logic [3:0] OPC_JZ   = 4'b1001;
   localparam logic [3:0] OPC_JO   = 4'b1010;
   localparam logic [3:0] OPC_PUSH = 4'b1100;

   typedef enum logic [2:0] {
      K_LD, K_ST, K_JMP, K_PUSH, K_POP, K_BAD
   } op_kind_t;

   typedef enum logic [1:0] {
      J_ALWAYS, J_ZERO, J_OVF
   } jcond_t;

   typedef enum logic [1:0] {
      S_FETCH, S_LATCH, S_EXEC, S_RDWAIT
   } state_t;

   typedef struct packed {
      op_kind_t           kind;
      logic               mode;
      jcond_t             cond;
      logic [RIW-1:0]     areg;
      logic [RIW-1:0]     dreg;
      logic [DFW-1:0]     dir;
      logic [IW-1:0]      imm;
   } dec_t;

endpackage

// File: rtl/msu_decode.sv
module msu_decode
   import msu_pkg::*;
(
   input  logic [IW-1:0] ir,
   output dec_t          dec
);

   logic [3:0] opc;
   assign opc = ir[15:12];

   always_comb begin
      dec.kind = K_BAD;
      dec.mode = 1'b0;
      dec.cond = J_ALWAYS;
      dec.areg = ir[2:0];
      dec.dreg = ir[2:0];
      dec.dir  = ir[10:0];
      dec.imm  = {{(IW-8){ir[7]}}, ir[7:0]};
      case (opc)
         OPC_LD: begin
            dec.kind = K_LD;
            dec.dreg = ir[11:9];
            dec.dir  = {2'b00, ir[8:0]};
         end
         OPC_ST: begin
            dec.kind = K_ST;
            dec.mode = ir[11];
            dec.areg = ir[5:3];
            dec.dir  = {3'b000, ir[10:3]};
         end
         OPC_JMP, OPC_JZ, OPC_JO: begin
            dec.kind = K_JMP;
            dec.mode = ir[11];
            if (opc == OPC_JZ)      dec.cond = J_ZERO;
            else if (opc == OPC_JO) dec.cond = J_OVF;
            else                    dec.cond = J_ALWAYS;
         end
         OPC_PUSH: begin
            dec.kind = K_PUSH;
            dec.mode = ir[8];
         end
         OPC_POP: begin
            dec.kind = K_POP;
            dec.mode = ir[11];
         end
         default: dec.kind = K_BAD;
      endcase
   end

endmodule

// File: rtl/msu_regfile.sv
module msu_regfile #(
   parameter int unsigned DW        = 16,
   parameter int unsigned RAW       = 3,
   parameter bit          CLEAR_RST = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [RAW-1:0] waddr,
   input  logic [DW-1:0]  wdata,
   input  logic [RAW-1:0] raddr_a,
   input  logic [RAW-1:0] raddr_b,
   output logic [DW-1:0]  rdata_a,
   output logic [DW-1:0]  rdata_b
);

   localparam int unsigned NREG = 1 << RAW;

   logic [NREG*DW-1:0] flat;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] q;
      logic          hit;
      assign hit = we && (waddr == RAW'(i));
      if (CLEAR_RST) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= wdata;
         end
      end
      assign flat[i*DW +: DW] = q;
   end

   assign rdata_a = flat[32'(raddr_a)*DW +: DW];
   assign rdata_b = flat[32'(raddr_b)*DW +: DW];

endmodule

// File: rtl/msu_seq.sv
module msu_seq
   import msu_pkg::*;
#(
   parameter int unsigned    AW      = 16,
   parameter logic [AW-1:0]  PC_INIT = '0,
   parameter logic [AW-1:0]  SP_INIT = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  op_kind_t       kind,
   input  logic           mode,
   input  jcond_t         cond,
   input  logic [DFW-1:0] dir,
   input  logic [IW-1:0]  imm,
   input  logic           zero_flag,
   input  logic           ovf_flag,
   input  logic [IW-1:0]  mem_rdata,
   input  logic [IW-1:0]  rf_a,
   input  logic [IW-1:0]  rf_b,
   output logic [IW-1:0]  ir,
   output logic [AW-1:0]  mem_addr,
   output logic [IW-1:0]  mem_wdata,
   output logic           mem_we,
   output logic           rf_we,
   output logic           retire,
   output logic           illegal,
   output state_t         st,
   output logic [AW-1:0]  pc,
   output logic [AW-1:0]  sp
);

   state_t        st_d;
   logic [AW-1:0] pc_d, sp_d, pc_inc, dir_addr, reg_addr;
   logic          ir_load, taken;

   assign pc_inc   = pc + AW'(1);
   assign dir_addr = AW'(dir);
   assign reg_addr = rf_a[AW-1:0];

   always_comb begin
      case (cond)
         J_ZERO:  taken = zero_flag;
         J_OVF:   taken = ovf_flag;
         default: taken = 1'b1;
      endcase
   end

   always_comb begin
      st_d      = st;
      pc_d      = pc;
      sp_d      = sp;
      mem_addr  = pc;
      mem_wdata = '0;
      mem_we    = 1'b0;
      rf_we     = 1'b0;
      retire    = 1'b0;
      illegal   = 1'b0;
      ir_load   = 1'b0;
      case (st)
         S_FETCH: st_d = S_LATCH;
         S_LATCH: begin
            ir_load = 1'b1;
            st_d    = S_EXEC;
         end
         S_EXEC: begin
            case (kind)
               K_LD: begin
                  mem_addr = dir_addr;
                  st_d     = S_RDWAIT;
               end
               K_ST: begin
                  mem_addr  = mode ? reg_addr : dir_addr;
                  mem_wdata = rf_b;
                  mem_we    = 1'b1;
                  pc_d      = pc_inc;
                  retire    = 1'b1;
                  st_d      = S_FETCH;
               end
               K_JMP: begin
                  pc_d   = taken ? (mode ? reg_addr : dir_addr) : pc_inc;
                  retire = 1'b1;
                  st_d   = S_FETCH;
               end
               K_PUSH: begin
                  sp_d      = sp - AW'(1);
                  mem_addr  = sp - AW'(1);
                  mem_wdata = mode ? imm : rf_b;
                  mem_we    = 1'b1;
                  pc_d      = pc_inc;
                  retire    = 1'b1;
                  st_d      = S_FETCH;
               end
               K_POP: begin
                  mem_addr = sp;
                  sp_d     = sp + AW'(1);
                  st_d     = S_RDWAIT;
               end
               default: begin
                  illegal = 1'b1;
                  retire  = 1'b1;
                  pc_d    = pc_inc;
                  st_d    = S_FETCH;
               end
            endcase
         end
         default: begin
            pc_d   = pc_inc;
            retire = 1'b1;
            st_d   = S_FETCH;
            if (kind == K_POP && mode) begin
               mem_addr  = dir_addr;
               mem_wdata = mem_rdata;
               mem_we    = 1'b1;
            end else begin
               rf_we = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_FETCH;
         pc <= PC_INIT;
         sp <= SP_INIT;
         ir <= '0;
      end else begin
         st <= st_d;
         pc <= pc_d;
         sp <= sp_d;
         if (ir_load) ir <= mem_rdata;
      end
   end

endmodule

// File: rtl/mem_stack_unit.sv
module mem_stack_unit
   import msu_pkg::*;
#(
   parameter int unsigned   AW        = 16,
   parameter logic [AW-1:0] PC_INIT   = '0,
   parameter logic [AW-1:0] SP_INIT   = '1,
   parameter bit            REG_CLEAR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          zero_flag,
   input  logic          ovf_flag,
   output logic [AW-1:0] mem_addr,
   output logic [IW-1:0] mem_wdata,
   output logic          mem_we,
   input  logic [IW-1:0] mem_rdata,
   output logic          retire,
   output logic          illegal
);

   if (AW < DFW || AW > IW) begin : g_bad_aw
      $error("mem_stack_unit: AW must lie between the jump field width and the word width");
   end

   logic [IW-1:0] ir;
   dec_t          dec;
   logic [IW-1:0] rf_a, rf_b;
   logic          rf_we;
   state_t        st;
   logic [AW-1:0] pc, sp;

   msu_decode u_dec (
      .ir  (ir),
      .dec (dec)
   );

   msu_regfile #(
      .DW        (IW),
      .RAW       (RIW),
      .CLEAR_RST (REG_CLEAR)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (dec.dreg),
      .wdata   (mem_rdata),
      .raddr_a (dec.areg),
      .raddr_b (dec.dreg),
      .rdata_a (rf_a),
      .rdata_b (rf_b)
   );

   msu_seq #(
      .AW      (AW),
      .PC_INIT (PC_INIT),
      .SP_INIT (SP_INIT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (dec.kind),
      .mode      (dec.mode),
      .cond      (dec.cond),
      .dir       (dec.dir),
      .imm       (dec.imm),
      .zero_flag (zero_flag),
      .ovf_flag  (ovf_flag),
      .mem_rdata (mem_rdata),
      .rf_a      (rf_a),
      .rf_b      (rf_b),
      .ir        (ir),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .rf_we     (rf_we),
      .retire    (retire),
      .illegal   (illegal),
      .st        (st),
      .pc        (pc),
      .sp        (sp)
   );

endmodule

// File: rtl/msu_checker.sv
module msu_checker
   import msu_pkg::*;
#(
   parameter int unsigned AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          retire,
   input logic          illegal,
   input logic          mem_we,
   input state_t        st,
   input op_kind_t      kind,
   input logic [AW-1:0] pc,
   input logic [AW-1:0] sp
);

   // R2: retire never lasts two cycles
   p_retire_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> !retire);

   // R2: program counter moves only at retire
   p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !retire |=> $stable(pc));

   // R2: non-jump instructions step the program counter by one
   p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && kind != K_JMP) |=> pc == $past(pc) + AW'(1));

   // R9: push pre-decrements the stack pointer
   p_push_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_EXEC && kind == K_PUSH) |=> sp == $past(sp) - AW'(1));

   // R11: pop post-increments the stack pointer
   p_pop_sp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_EXEC && kind == K_POP) |=> sp == $past(sp) + AW'(1));

   // R11: stack pointer is untouched outside push and pop execution
   p_sp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(st == S_EXEC && (kind == K_PUSH || kind == K_POP)) |=> $stable(sp));

   // R13: an illegal opcode retires and writes nothing
   p_bad_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (retire && !mem_we));

   // R4: writes appear only in execute or read-wait slots
   p_we_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (st == S_EXEC || st == S_RDWAIT));

endmodule

bind mem_stack_unit msu_checker #(.AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .retire  (retire),
   .illegal (illegal),
   .mem_we  (mem_we),
   .st      (st),
   .kind    (dec.kind),
   .pc      (pc),
   .sp      (sp)
);

// File: tb/mem_stack_unit_bench.sv
module mem_stack_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int EV_FETCH = 0;
   localparam int EV_WRITE = 1;
   localparam int EV_BAD   = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        zero_flag = 1'b0;
   logic        ovf_flag = 1'b0;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we, retire, illegal;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_stack_unit u_mem_stack_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .zero_flag (zero_flag),
      .ovf_flag  (ovf_flag),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .retire    (retire),
      .illegal   (illegal)
   );

   // memory seen by the design and the bench's own model of it
   bit [15:0]   mem [int];
   bit [15:0]   mdl_mem [int];
   logic [15:0] m_reg [8];
   logic [15:0] m_pc, m_sp;
   string       next_tag = "";

   int          q_kind[$];
   logic [15:0] q_addr[$];
   logic [15:0] q_data[$];
   string       q_tag[$];
   logic        q_zf[$];
   logic        q_of[$];

   int n_chk = 0;
   int n_bad = 0;

   function automatic logic [15:0] drd(int a);
      return mem.exists(a) ? mem[a] : 16'h0000;
   endfunction

   function automatic logic [15:0] mrd(int a);
      return mdl_mem.exists(a) ? mdl_mem[a] : 16'h0000;
   endfunction

   always @(posedge clk) begin
      mem_rdata <= drd(int'(mem_addr));
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic ev(int k, logic [15:0] a, logic [15:0] d, string t);
      q_kind.push_back(k);
      q_addr.push_back(a);
      q_data.push_back(d);
      q_tag.push_back(t);
   endtask

   task automatic poke(int a, logic [15:0] d);
      mem[a] = d;
      mdl_mem[a] = d;
   endtask

   // places an instruction at the model pc and expects its fetch
   task automatic emit(logic [15:0] word, logic zf, logic of, int lat, string t);
      string ft;
      ft = (next_tag != "") ? next_tag : t;
      next_tag = "";
      mem[int'(m_pc)] = word;
      ev(EV_FETCH, m_pc, 16'(lat), ft);
      q_zf.push_back(zf);
      q_of.push_back(of);
   endtask

   task automatic op_ld(logic [2:0] rd, logic [8:0] a);
      emit({4'b0110, rd, a}, 1'b1, 1'b0, 4, "R2");
      m_reg[rd] = mrd(int'(a));
      m_pc++;
   endtask

   task automatic op_st_dir(logic [7:0] a, logic [2:0] rs, string t);
      emit({4'b0111, 1'b0, a, rs}, 1'b0, 1'b1, 3, "R2");
      ev(EV_WRITE, {8'h00, a}, m_reg[rs], t);
      mdl_mem[int'(a)] = m_reg[rs];
      m_pc++;
   endtask

   task automatic op_st_ind(logic [2:0] ra, logic [2:0] rs, string t);
      emit({4'b0111, 1'b1, 5'b00000, ra, rs}, 1'b1, 1'b1, 3, "R2");
      ev(EV_WRITE, m_reg[ra], m_reg[rs], t);
      mdl_mem[int'(m_reg[ra])] = m_reg[rs];
      m_pc++;
   endtask

   task automatic op_push_reg(logic [2:0] rs, string t);
      emit({4'b1100, 3'b000, 1'b0, 5'b00000, rs}, 1'b1, 1'b0, 3, "R2");
      m_sp = m_sp - 16'd1;
      ev(EV_WRITE, m_sp, m_reg[rs], t);
      mdl_mem[int'(m_sp)] = m_reg[rs];
      m_pc++;
   endtask

   task automatic op_push_imm(logic [7:0] v, string t);
      logic [15:0] d;
      emit({4'b1100, 3'b000, 1'b1, v}, 1'b0, 1'b0, 3, "R2");
      d = {{8{v[7]}}, v};
      m_sp = m_sp - 16'd1;
      ev(EV_WRITE, m_sp, d, t);
      mdl_mem[int'(m_sp)] = d;
      m_pc++;
   endtask

   task automatic op_pop_reg(logic [2:0] rd);
      emit({4'b0011, 1'b0, 8'h00, rd}, 1'b0, 1'b1, 4, "R2");
      m_reg[rd] = mrd(int'(m_sp));
      m_sp = m_sp + 16'd1;
      m_pc++;
   endtask

   task automatic op_pop_mem(logic [10:0] a, string t);
      logic [15:0] d;
      emit({4'b0011, 1'b1, a}, 1'b1, 1'b1, 4, "R2");
      d = mrd(int'(m_sp));
      m_sp = m_sp + 16'd1;
      ev(EV_WRITE, {5'b00000, a}, d, t);
      mdl_mem[int'(a)] = d;
      m_pc++;
   endtask

   task automatic op_jmp(logic [3:0] opc, logic md, logic [10:0] f, logic zf, logic of, string t);
      logic [15:0] tgt;
      logic        tk;
      emit({opc, md, f}, zf, of, 3, t);
      tgt = md ? m_reg[f[2:0]] : {5'b00000, f};
      tk  = (opc == 4'b1000) || (opc == 4'b1001 && zf) || (opc == 4'b1010 && of);
      m_pc = tk ? tgt : m_pc + 16'd1;
      next_tag = t;
   endtask

   task automatic op_bad(logic [15:0] word);
      emit(word, 1'b1, 1'b1, 3, "R2");
      ev(EV_BAD, m_pc, 16'h0000, "R13");
      m_pc++;
      next_tag = "R13";
   endtask

   task automatic build;
      m_pc = 16'h0000;
      m_sp = 16'hFFFF;
      for (int i = 0; i < 8; i++) m_reg[i] = 16'h0000;
      poke(16'h1F0, 16'h1234);
      poke(16'h1F2, 16'h00E0);
      poke(16'h1FF, 16'h0900);
      op_ld(3'd1, 9'h1F0);
      op_ld(3'd7, 9'h1FF);
      op_ld(3'd4, 9'h1F2);
      op_st_dir(8'hC0, 3'd1, "R3");
      op_st_dir(8'hFF, 3'd7, "R4");
      op_push_imm(8'h85, "R10");
      op_push_imm(8'h7F, "R10");
      op_push_reg(3'd1, "R9");
      op_pop_reg(3'd2);
      op_pop_mem(11'h7FF, "R12");
      op_pop_reg(3'd3);
      op_st_ind(3'd4, 3'd3, "R5");
      op_st_ind(3'd2, 3'd2, "R5");
      op_st_dir(8'hC1, 3'd3, "R11");
      op_st_dir(8'hC5, 3'd0, "R1");
      op_jmp(4'b1001, 1'b0, 11'h040, 1'b0, 1'b1, "R8");
      op_jmp(4'b1001, 1'b0, 11'h013, 1'b1, 1'b0, "R8");
      op_jmp(4'b1010, 1'b0, 11'h030, 1'b1, 1'b0, "R8");
      op_jmp(4'b1010, 1'b0, 11'h01A, 1'b0, 1'b1, "R8");
      op_jmp(4'b1000, 1'b0, 11'h01E, 1'b0, 1'b0, "R6");
      op_bad(16'h0000);
      op_bad(16'hF5A5);
      op_bad(16'h4123);
      op_st_dir(8'hC2, 3'd1, "R13");
      op_jmp(4'b1000, 1'b1, 11'h007, 1'b1, 1'b1, "R7");
      op_st_dir(8'hC3, 3'd7, "R7");
      op_push_reg(3'd2, "R9");
      op_jmp(4'b1001, 1'b1, 11'h004, 1'b1, 1'b0, "R8");
      // fetch at the indirect target in r4, checked without placing a word there
      ev(EV_FETCH, m_reg[4], 16'd0, "R8");
      q_zf.push_back(1'b0);
      q_of.push_back(1'b0);
   endtask

   // monitor: pops expected items as the design produces them
   initial begin : monitor
      bit fetch_due;
      bit have_lat;
      int cyc;
      int lat;
      fetch_due = 1'b1;
      have_lat  = 1'b0;
      cyc = 0;
      lat = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            fetch_due = 1'b1;
         end else begin
            if (fetch_due) begin
               fetch_due = 1'b0;
               cyc = 1;
               have_lat = 1'b0;
               if (q_kind.size() != 0) begin
                  chk(q_tag[0], "event kind (fetch)", 32'(EV_FETCH), 32'(q_kind[0]));
                  chk(q_tag[0], "fetch address", {16'h0, mem_addr}, {16'h0, q_addr[0]});
                  lat = int'(q_data[0]);
                  have_lat = (lat != 0);
                  zero_flag = q_zf.pop_front();
                  ovf_flag  = q_of.pop_front();
                  void'(q_kind.pop_front());
                  void'(q_addr.pop_front());
                  void'(q_data.pop_front());
                  void'(q_tag.pop_front());
               end
            end else begin
               cyc++;
            end
            if (mem_we && q_kind.size() != 0) begin
               chk(q_tag[0], "event kind (write)", 32'(EV_WRITE), 32'(q_kind[0]));
               chk(q_tag[0], "write address", {16'h0, mem_addr}, {16'h0, q_addr[0]});
               chk(q_tag[0], "write data", {16'h0, mem_wdata}, {16'h0, q_data[0]});
               void'(q_kind.pop_front());
               void'(q_addr.pop_front());
               void'(q_data.pop_front());
               void'(q_tag.pop_front());
            end
            if (illegal && q_kind.size() != 0) begin
               chk(q_tag[0], "event kind (illegal)", 32'(EV_BAD), 32'(q_kind[0]));
               chk(q_tag[0], "illegal with retire", {31'h0, retire}, 32'd1);
               void'(q_kind.pop_front());
               void'(q_addr.pop_front());
               void'(q_data.pop_front());
               void'(q_tag.pop_front());
            end
            if (retire) begin
               if (have_lat) chk("R2", "cycles fetch to retire", 32'(cyc), 32'(lat));
               have_lat  = 1'b0;
               fetch_due = 1'b1;
            end
         end
      end
   end

   initial begin : driver
      int waited;
      build();
      repeat (3) @(negedge clk);
      chk("R1", "retire in reset", {31'h0, retire}, 32'd0);
      chk("R1", "illegal in reset", {31'h0, illegal}, 32'd0);
      chk("R1", "mem_we in reset", {31'h0, mem_we}, 32'd0);
      chk("R1", "address in reset", {16'h0, mem_addr}, 32'h0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      waited = 0;
      while (q_kind.size() != 0 && waited < 5000) begin
         @(negedge clk);
         waited++;
      end
      if (q_kind.size() != 0) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d pending expected=0 pending", q_kind.size());
      end
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule